// File: doc/BRIEF.md
# MSI Vector Capture Controller

This block watches an inbound memory-write stream for message-signalled interrupts. A write is a message when its full 64-bit address equals the target address that software has programmed. When it is a message, its data word is taken as a flat vector number. That number selects one pending bit inside a set of 32-vector banks. The vector is recorded only if software has enabled it.

Software reaches the block over a small 32-bit register bus. Through it, software sets the target address and, for each bank, a word of enable bits, a word of mask bits and a pending-status word. The status word is cleared by writing ones. A single level interrupt output stays asserted while any vector is pending, enabled and unmasked. A masked vector still records its pending bit, so it is delivered as soon as its mask bit is removed.

Top module: `msi_vector_catcher`

## Requirements
- R1: After reset, every enable, mask and status bit is 0, both target address words are 0, and `irq_out` is low.
- R2: The target address low word is read and written at register offset 0x820 and the high word at 0x824. A message must match the 64-bit value {high, low}.
- R3: Bank b has its enable word at 0x828+12*b and its mask word at 0x82C+12*b. Both are plain read/write words, so a read-modify-write of one bit preserves the other bits.
- R4: When the message address matches and the vector v = data is enabled, status bit v%32 of bank v/32 (read at 0x830+12*b) becomes 1 one clock after the write.
- R5: An inbound write whose 64-bit address differs from the target in any bit, including the upper 32, leaves all status bits unchanged.
- R6: A message naming a vector whose enable bit is 0 leaves status unchanged.
- R7: A message with data at or above 32*NUM_BANKS leaves status unchanged. In particular it does not wrap onto a low vector.
- R8: In a status word, a register write of 1 clears that bit and a write of 0 leaves it unchanged.
- R9: `irq_out` is high exactly while some bank has a bit that is 1 in status, 1 in enable and 0 in mask.
- R10: A masked, enabled vector still records its status bit on a message. `irq_out` rises once its mask bit is cleared.
- R11: If a message sets a status bit in the same cycle that a write-one-to-clear targets that bit, the bit ends up set.
- R12: A read at an offset that maps to no register returns 0. Read data appears on `reg_rdata` one clock after `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Inbound memory write present this cycle |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data (flat vector number) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one clock after `reg_re` |
| irq_out | output | 1 | Combined interrupt level |

## Verification
Two functions can act on the same status bit in one clock: capturing an inbound message and clearing status by writing ones from software. The bench provokes this collision by driving a matching message for vector 6 in the same cycle as a write of 0x40 to bank 0's status word. It then reads the word back and expects bit 6 still set. A second case clears one bit while a message sets a neighbouring bit in the same cycle; both results are checked in the readback. A scoreboard queue holds the expected read data and compares it one clock after each read strobe.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam logic [11:0] OFS_TGT_LO    = 12'h820;
  localparam logic [11:0] OFS_TGT_HI    = 12'h824;
  localparam logic [11:0] OFS_BANK_BASE = 12'h828;
  localparam int          BANK_STRIDE   = 12;
  localparam int          VEC_PER_BANK  = 32;

  typedef enum logic [2:0] {
    RK_NONE, RK_TGT_LO, RK_TGT_HI, RK_ENA, RK_MSK, RK_STS
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] bank;
  } reg_sel_t;

  // bank index of a flat vector number
  function automatic logic [31:0] vec_bank(input logic [31:0] v);
    return v >> 5;
  endfunction

  // bit position of a flat vector number inside its bank
  function automatic logic [4:0] vec_bit(input logic [31:0] v);
    return v[4:0];
  endfunction

  // byte offset of word w (0 enable, 1 mask, 2 status) of bank b
  function automatic logic [11:0] bank_ofs(input int b, input int w);
    return 12'(int'(OFS_BANK_BASE) + b * BANK_STRIDE + w * 4);
  endfunction

  function automatic reg_sel_t reg_decode(input logic [11:0] a, input int nbanks);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.bank = '0;
    if (a == OFS_TGT_LO) s.kind = RK_TGT_LO;
    else if (a == OFS_TGT_HI) s.kind = RK_TGT_HI;
    else begin
      for (int b = 0; b < nbanks; b++) begin
        if (a == bank_ofs(b, 0)) begin s.kind = RK_ENA; s.bank = 8'(b); end
        if (a == bank_ofs(b, 1)) begin s.kind = RK_MSK; s.bank = 8'(b); end
        if (a == bank_ofs(b, 2)) begin s.kind = RK_STS; s.bank = 8'(b); end
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/msi_msg_decode.sv
module msi_msg_decode
  import msi_cap_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                       msg_valid,
  input  logic [63:0]                msg_addr,
  input  logic [31:0]                msg_data,
  input  logic [31:0]                tgt_lo,
  input  logic [31:0]                tgt_hi,
  output logic                       fire,
  output logic [NUM_BANKS-1:0][31:0] hit
);
  localparam int NUM_VEC = NUM_BANKS * VEC_PER_BANK;

  logic addr_match;
  logic in_range;

  assign addr_match = (msg_addr == {tgt_hi, tgt_lo});
  assign in_range   = (msg_data < 32'(NUM_VEC));
  assign fire       = msg_valid && addr_match && in_range;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign hit[b] = (fire && (vec_bank(msg_data) == 32'(b)))
                  ? (32'd1 << vec_bit(msg_data)) : 32'd0;
  end

endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ena_we,
  input  logic        msk_we,
  input  logic        sts_we,
  input  logic [31:0] wdata,
  input  logic [31:0] set_req,
  output logic [31:0] ena_q,
  output logic [31:0] msk_q,
  output logic [31:0] sts_q,
  output logic        pend_any
);
  logic [31:0] set_eff;
  logic [31:0] clr_req;
  logic [31:0] sts_d;

  assign set_eff  = set_req & ena_q;
  assign clr_req  = sts_we ? wdata : 32'd0;
  assign sts_d    = (sts_q & ~clr_req) | set_eff;
  assign pend_any = |(sts_q & ena_q & ~msk_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q <= '0;
      msk_q <= '0;
      sts_q <= '0;
    end else begin
      if (ena_we) ena_q <= wdata;
      if (msk_we) msk_q <= wdata;
      sts_q <= sts_d;
    end
  end

  // R4 / R10: an accepted capture leaves its bit set, mask or not
  p_capture_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_eff) |=> ((sts_q & $past(set_eff)) == $past(set_eff)));

  // R6: no status bit rises unless it was enabled the cycle before
  p_no_set_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(ena_q)) == 32'd0));

  // R8: a cleared bit with no concurrent capture is 0 afterwards
  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_req & ~set_eff)) |=> ((sts_q & $past(clr_req & ~set_eff)) == 32'd0));

  // R11: capture beats clear on the same bit
  p_capture_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_req & set_eff)) |=> ((sts_q & $past(clr_req & set_eff)) == $past(clr_req & set_eff)));

endmodule

// File: rtl/msi_reg_file.sv
module msi_reg_file
  import msi_cap_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic                       reg_re,
  input  logic [11:0]                reg_addr,
  input  logic [31:0]                reg_wdata,
  input  logic [NUM_BANKS-1:0][31:0] ena_all,
  input  logic [NUM_BANKS-1:0][31:0] msk_all,
  input  logic [NUM_BANKS-1:0][31:0] sts_all,
  output logic [31:0]                tgt_lo,
  output logic [31:0]                tgt_hi,
  output logic [NUM_BANKS-1:0]       ena_we,
  output logic [NUM_BANKS-1:0]       msk_we,
  output logic [NUM_BANKS-1:0]       sts_we,
  output logic [31:0]                reg_rdata
);
  reg_sel_t    sel;
  logic [31:0] rd_mux;

  assign sel = reg_decode(reg_addr, NUM_BANKS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
    assign ena_we[b] = reg_we && (sel.kind == RK_ENA) && (sel.bank == 8'(b));
    assign msk_we[b] = reg_we && (sel.kind == RK_MSK) && (sel.bank == 8'(b));
    assign sts_we[b] = reg_we && (sel.kind == RK_STS) && (sel.bank == 8'(b));
  end

  always_comb begin
    rd_mux = 32'd0;
    case (sel.kind)
      RK_TGT_LO: rd_mux = tgt_lo;
      RK_TGT_HI: rd_mux = tgt_hi;
      default: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (sel.bank == 8'(b)) begin
            if (sel.kind == RK_ENA) rd_mux = ena_all[b];
            if (sel.kind == RK_MSK) rd_mux = msk_all[b];
            if (sel.kind == RK_STS) rd_mux = sts_all[b];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_lo    <= '0;
      tgt_hi    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && sel.kind == RK_TGT_LO) tgt_lo <= reg_wdata;
      if (reg_we && sel.kind == RK_TGT_HI) tgt_hi <= reg_wdata;
      if (reg_re) reg_rdata <= rd_mux;
    end
  end

  // R2: target words only move on a register write
  p_tgt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(tgt_lo) && $stable(tgt_hi)));

  // R3: at most one bank word is strobed per write
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ena_we, msk_we, sts_we}) <= 1);

endmodule

// File: rtl/msi_vector_catcher.sv
module msi_vector_catcher
  import msi_cap_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msg_valid,
  input  logic [63:0] msg_addr,
  input  logic [31:0] msg_data,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_out
);
  localparam int NUM_VEC = NUM_BANKS * VEC_PER_BANK;

  logic [31:0]                tgt_lo;
  logic [31:0]                tgt_hi;
  logic                       msg_fire;
  logic [NUM_BANKS-1:0][31:0] hit;
  logic [NUM_BANKS-1:0][31:0] ena_all;
  logic [NUM_BANKS-1:0][31:0] msk_all;
  logic [NUM_BANKS-1:0][31:0] sts_all;
  logic [NUM_BANKS-1:0]       ena_we;
  logic [NUM_BANKS-1:0]       msk_we;
  logic [NUM_BANKS-1:0]       sts_we;
  logic [NUM_BANKS-1:0]       pend;

  msi_msg_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .tgt_lo    (tgt_lo),
    .tgt_hi    (tgt_hi),
    .fire      (msg_fire),
    .hit       (hit)
  );

  msi_reg_file #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ena_all   (ena_all),
    .msk_all   (msk_all),
    .sts_all   (sts_all),
    .tgt_lo    (tgt_lo),
    .tgt_hi    (tgt_hi),
    .ena_we    (ena_we),
    .msk_we    (msk_we),
    .sts_we    (sts_we),
    .reg_rdata (reg_rdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    msi_vec_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ena_we   (ena_we[b]),
      .msk_we   (msk_we[b]),
      .sts_we   (sts_we[b]),
      .wdata    (reg_wdata),
      .set_req  (hit[b]),
      .ena_q    (ena_all[b]),
      .msk_q    (msk_all[b]),
      .sts_q    (sts_all[b]),
      .pend_any (pend[b])
    );
  end

  assign irq_out = |pend;

  // R7: an out-of-range vector never produces a capture request
  p_range_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_data >= 32'(NUM_VEC)) |-> (hit == '0));

  // R5: a mismatching address never produces a capture request
  p_addr_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_addr != {tgt_hi, tgt_lo}) |-> (hit == '0));

  // R9: the interrupt only rises after a capture or a register write
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(msg_fire || reg_we));

endmodule

// File: tb/msi_vector_catcher_tb.sv
module msi_vector_catcher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_vector_catcher #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // bench-side offset arithmetic
  function automatic logic [11:0] ena_ofs(input int b); return 12'h828 + 12'(12*b); endfunction
  function automatic logic [11:0] msk_ofs(input int b); return 12'h82C + 12'(12*b); endfunction
  function automatic logic [11:0] sts_ofs(input int b); return 12'h830 + 12'(12*b); endfunction

  localparam logic [31:0] TGT = 32'hFEE0_1000;

  // monitor: compare read data one clock after the strobe
  always @(posedge clk) rd_seen <= reg_re;
  always @(negedge clk) begin
    if (rd_seen) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: read with no expectation, got %h", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata=%h expected=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic send_msg(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = a; msg_data = d;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  // message and status write in the same clock
  task automatic msg_and_clear(input logic [31:0] d, input int b, input logic [31:0] clr);
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = {32'd0, TGT}; msg_data = d;
    reg_we = 1'b1; reg_addr = sts_ofs(b); reg_wdata = clr;
    @(negedge clk);
    msg_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    @(negedge clk);
    n_checks++;
    if (irq_out !== e) begin
      n_fail++;
      $display("FAIL %s: irq_out=%b expected=%b", t, irq_out, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_irq(1'b0, "R1 irq after reset");
    reg_read(12'h820, 32'd0, "R1 target lo");
    reg_read(12'h824, 32'd0, "R1 target hi");
    reg_read(ena_ofs(0), 32'd0, "R1 enable bank0");
    reg_read(msk_ofs(5), 32'd0, "R1 mask bank5");
    reg_read(sts_ofs(7), 32'd0, "R1 status bank7");

    // R2 target address
    reg_write(12'h820, TGT);
    reg_write(12'h824, 32'd0);
    reg_read(12'h820, TGT, "R2 target lo");
    reg_read(12'h824, 32'd0, "R2 target hi");

    // R3 enable / mask words
    reg_write(ena_ofs(0), 32'h0000_00F0);
    reg_write(ena_ofs(7), 32'h8000_0001);
    reg_write(msk_ofs(3), 32'h0000_A5A5);
    reg_read(ena_ofs(0), 32'h0000_00F0, "R3 enable bank0");
    reg_read(ena_ofs(7), 32'h8000_0001, "R3 enable bank7");
    reg_read(msk_ofs(3), 32'h0000_A5A5, "R3 mask bank3");

    // R4 capture, R9 irq
    send_msg({32'd0, TGT}, 32'd4);
    reg_read(sts_ofs(0), 32'h0000_0010, "R4 vector 4 captured");
    check_irq(1'b1, "R9 irq with pending vector");

    // R8 write one to clear
    reg_write(sts_ofs(0), 32'h0000_0000);
    reg_read(sts_ofs(0), 32'h0000_0010, "R8 zero write keeps bit");
    reg_write(sts_ofs(0), 32'h0000_0010);
    reg_read(sts_ofs(0), 32'h0000_0000, "R8 one write clears bit");
    check_irq(1'b0, "R9 irq after clear");

    // R5 address mismatch
    send_msg({32'd0, TGT + 32'd4}, 32'd5);
    send_msg({32'd1, TGT}, 32'd5);
    reg_read(sts_ofs(0), 32'h0000_0000, "R5 mismatched address ignored");
    check_irq(1'b0, "R5 irq stays low");

    // R6 disabled vector
    send_msg({32'd0, TGT}, 32'd0);
    reg_read(sts_ofs(0), 32'h0000_0000, "R6 disabled vector ignored");

    // R3 read-modify-write keeps other bits
    reg_write(ena_ofs(0), 32'h0000_00F0 | 32'h1);
    reg_read(ena_ofs(0), 32'h0000_00F1, "R3 rmw preserves enable bits");

    // R7 out of range
    send_msg({32'd0, TGT}, 32'd256);
    send_msg({32'd0, TGT}, 32'hFFFF_FFFF);
    reg_read(sts_ofs(0), 32'h0000_0000, "R7 out-of-range no wrap");
    reg_read(sts_ofs(7), 32'h0000_0000, "R7 top bank untouched");

    // R4 highest vector
    send_msg({32'd0, TGT}, 32'd255);
    reg_read(sts_ofs(7), 32'h8000_0000, "R4 vector 255 captured");
    check_irq(1'b1, "R9 irq from bank7");
    reg_write(sts_ofs(7), 32'h8000_0000);
    check_irq(1'b0, "R9 irq after bank7 clear");

    // R10 masked vector records, delivers on unmask
    reg_write(msk_ofs(0), 32'h0000_0020);
    send_msg({32'd0, TGT}, 32'd5);
    reg_read(sts_ofs(0), 32'h0000_0020, "R10 masked vector recorded");
    check_irq(1'b0, "R10 irq held while masked");
    reg_write(msk_ofs(0), 32'h0000_0000);
    check_irq(1'b1, "R10 irq on unmask");
    reg_write(sts_ofs(0), 32'h0000_0020);
    check_irq(1'b0, "R8 irq after clearing vector 5");

    // R11 capture vs clear on the same bit
    send_msg({32'd0, TGT}, 32'd6);
    msg_and_clear(32'd6, 0, 32'h0000_0040);
    reg_read(sts_ofs(0), 32'h0000_0040, "R11 capture wins same bit");
    // neighbouring bits in the same cycle
    msg_and_clear(32'd7, 0, 32'h0000_0040);
    reg_read(sts_ofs(0), 32'h0000_0080, "R11 clear one bit, capture another");

    // R12 unmapped offsets
    reg_read(12'h900, 32'd0, "R12 unmapped 0x900");
    reg_read(12'h81C, 32'd0, "R12 unmapped 0x81C");
    reg_read(12'h888, 32'd0, "R12 past last bank");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: %0d reads unanswered, expected 0", exp_q.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule